// File: doc/BRIEF.md
# T1/E1 Transmit Signaling Inserter

This block writes per-channel signaling bits into a byte-serial transmit PCM stream. It works in three framing modes: T1 extended superframe, T1 twelve-frame superframe and E1 with channel-associated signaling. Each input beat carries one time-slot byte. The beat also carries the slot and frame indices, which an external framer counts, and one byte from a serial signaling stream that runs in step with the PCM data. The block returns each byte one clock later, with the signaling bits written in where the mode calls for them.

Each channel has two possible signaling sources. The first is a bank of host-written registers. The host writes these registers freely, but the working shadow copy that feeds insertion is refreshed only at a multiframe boundary, so a multiframe is never built from mixed data. The second source is the serial stream. Two 32-bit masks pick the source for each channel, and the serial stream wins when both masks select the same channel. A sticky flag tells the host that a new multiframe has started. Reading the flag clears it.

Top module: `tx_sig_inserter`

## Requirements
- R1: After synchronous reset, `out_vld`, `pcm_out` and `stat_mf` are all 0. All bank and shadow registers are 0.
- R2: Each beat with `in_vld`=1 appears on `pcm_out` exactly one clock later, with `out_vld`=1. A clock with `in_vld`=0 gives `out_vld`=0 one clock later.
- R3: A multiframe boundary is a valid beat with slot 0 and frame 0. On that clock edge the shadow copies the whole bank. A write made on the boundary beat or at any later point takes effect at the following boundary. A register that is not rewritten keeps its value.
- R4: `stat_mf` becomes 1 on the clock after a boundary beat. It becomes 0 on the clock after a `stat_rd` pulse. When both happen on the same clock, setting wins.
- R5: T1 register layout: register r holds channel 2r in bits 7:4 and channel 2r+1 in bits 3:0. Within a nibble, bit 3 is A, bit 2 is B, bit 1 is C and bit 0 is D. Channel n is slot n, for n from 0 to 23.
- R6: In mode 00 (T1 ESF, frames 0 to 23), frames 5, 11, 17 and 23 replace bit 0 of each enabled channel byte with A, B, C and D, in that order. Every other bit and every other frame passes through unchanged.
- R7: In mode 01 (T1 D4, frames 0 to 11), frames 5 and 11 replace bit 0 with A and B. The C and D bits of the source have no effect on the output.
- R8: In mode 10 (E1 CAS, frames 0 to 15), slot 16 of frame 0 gets 0000 in bits 7:4, and its bits 3:0 pass through. In frames 1 to 15, register f fills slot 16: bits 7:4 carry the ABCD of slot f and bits 3:0 carry the ABCD of slot f+16.
- R9: In T1 modes, the serial source gives ABCD in `sig_in[3:0]` on the channel's own beat, with A in bit 3. In E1 mode, the serial source gives the whole slot-16 byte in the same layout as R8, on the slot-16 beat.
- R10: If a channel is set in both `hw_mask` and `sw_mask`, the serial stream is inserted for it.
- R11: A channel set in neither mask passes unchanged. In E1 mode, every slot other than 16 passes unchanged.
- R12: Mode 11 passes every byte through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 T1 ESF, 01 T1 D4, 10 E1 CAS, 11 pass-through |
| in_vld | input | 1 | Input beat valid |
| slot_idx | input | 5 | Time slot of the current beat |
| frame_idx | input | 5 | Frame number within the multiframe |
| pcm_in | input | 8 | Transmit PCM byte |
| sig_in | input | 8 | Serial signaling byte aligned with the beat |
| sw_mask | input | 32 | Per-channel enable for the register bank |
| hw_mask | input | 32 | Per-channel select for the serial stream |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 4 | Host register index |
| wr_data | input | 8 | Host write data |
| stat_rd | input | 1 | Host read of the multiframe flag (clears it) |
| out_vld | output | 1 | Output beat valid |
| pcm_out | output | 8 | PCM byte after insertion |
| stat_mf | output | 1 | Sticky multiframe-boundary flag |

## Verification
The hardest case to reach is a host write that lands exactly on the boundary beat. On that same edge the shadow takes the bank's old content. The new value must stay invisible for the whole next multiframe and must appear only after the boundary that follows. The bench makes that write on a boundary beat and makes another write in the middle of a multiframe. It then sweeps every slot of every frame over several multiframes in each mode. The masks overlap, so every channel falls into one of four cases: serial only, bank only, both, or neither. An arithmetic model in the bench, with its own bank and shadow, predicts every output byte.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic [1:0] {
    MODE_ESF = 2'b00,
    MODE_D4  = 2'b01,
    MODE_E1  = 2'b10,
    MODE_OFF = 2'b11
  } sig_mode_e;
endpackage

// File: rtl/tsi_bank.sv
// Host register bank, boundary-loaded shadow and sticky multiframe flag.
module tsi_bank #(
  parameter int NREG = 16,
  localparam int RW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              mf_bnd,
  input  logic              stat_rd,
  output logic [NREG*8-1:0] shadow_flat,
  output logic              stat_mf
);
  logic [7:0] bank [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else if (wr_en) begin
      bank[wr_addr] <= wr_data;
    end
  end

  // The whole bank is copied in one edge, so it is read in parallel.
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_flat <= '0;
    end else if (mf_bnd) begin
      for (int i = 0; i < NREG; i++) shadow_flat[i*8 +: 8] <= bank[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          stat_mf <= 1'b0;
    else if (mf_bnd)  stat_mf <= 1'b1;
    else if (stat_rd) stat_mf <= 1'b0;
  end

  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !mf_bnd |=> $stable(shadow_flat));
  p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
    mf_bnd |=> stat_mf);
  p_flag_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !mf_bnd) |=> !stat_mf);
endmodule

// File: rtl/tsi_insert.sv
// Source selection and bit insertion, registered output.
module tsi_insert
  import tsi_pkg::*;
#(
  parameter int NSLOT = 32,
  parameter int T1_CH = 24,
  localparam int SW   = $clog2(NSLOT),
  localparam int NREG = NSLOT / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  sig_mode_e         mode,
  input  logic              in_vld,
  input  logic [SW-1:0]     slot,
  input  logic [4:0]        frame,
  input  logic [7:0]        in_data,
  input  logic [7:0]        sig_in,
  input  logic [NSLOT-1:0]  hw_mask,
  input  logic [NSLOT-1:0]  sw_mask,
  input  logic [NREG*8-1:0] shadow_flat,
  output logic              out_vld,
  output logic [7:0]        out_data
);
  localparam logic [SW-1:0] E1_SIG_SLOT = SW'(NSLOT / 2);

  logic [7:0] sh [NREG];
  for (genvar g = 0; g < NREG; g++) begin : g_unflat
    assign sh[g] = shadow_flat[g*8 +: 8];
  end

  logic         rob_hit;
  logic [1:0]   rob_k;
  logic [7:0]   t1_reg, e1_reg;
  logic [3:0]   t1_nib;
  logic [SW-1:0] up_ch, lo_ch;
  logic [7:0]   nxt;

  // Which robbed-bit frame, and which of A..D it carries.
  always_comb begin
    rob_hit = 1'b0;
    rob_k   = 2'd0;
    unique case (frame)
      5'd5:  begin rob_hit = 1'b1; rob_k = 2'd0; end
      5'd11: begin rob_hit = 1'b1; rob_k = 2'd1; end
      5'd17: begin rob_hit = (mode == MODE_ESF); rob_k = 2'd2; end
      5'd23: begin rob_hit = (mode == MODE_ESF); rob_k = 2'd3; end
      default: ;
    endcase
  end

  assign t1_reg = sh[slot[SW-1:1]];
  assign t1_nib = hw_mask[slot] ? sig_in[3:0]
                : (slot[0] ? t1_reg[3:0] : t1_reg[7:4]);
  assign e1_reg = sh[frame[SW-2:0]];
  assign up_ch  = {1'b0, frame[SW-2:0]};
  assign lo_ch  = {1'b1, frame[SW-2:0]};

  always_comb begin
    nxt = in_data;
    unique case (mode)
      MODE_ESF, MODE_D4: begin
        if (slot < SW'(T1_CH) && rob_hit && (hw_mask[slot] || sw_mask[slot]))
          nxt[0] = t1_nib[2'd3 - rob_k];
      end
      MODE_E1: begin
        if (slot == E1_SIG_SLOT) begin
          if (frame == 5'd0) begin
            nxt[7:4] = 4'b0000;
          end else if (frame < 5'(NREG)) begin
            if (hw_mask[up_ch])      nxt[7:4] = sig_in[7:4];
            else if (sw_mask[up_ch]) nxt[7:4] = e1_reg[7:4];
            if (hw_mask[lo_ch])      nxt[3:0] = sig_in[3:0];
            else if (sw_mask[lo_ch]) nxt[3:0] = e1_reg[3:0];
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_data <= nxt;
    end
  end

  p_vld_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  p_vld_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);
  p_off_pass_r12: assert property (@(posedge clk) disable iff (rst)
    (in_vld && mode == MODE_OFF) |=> out_data == $past(in_data));
  p_t1_upper_r6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && mode != MODE_E1) |=> out_data[7:1] == $past(in_data[7:1]));
  p_e1_other_r11: assert property (@(posedge clk) disable iff (rst)
    (in_vld && mode == MODE_E1 && slot != E1_SIG_SLOT) |=> out_data == $past(in_data));
  p_e1_align_r8: assert property (@(posedge clk) disable iff (rst)
    (in_vld && mode == MODE_E1 && slot == E1_SIG_SLOT && frame == 5'd0)
      |=> out_data[7:4] == 4'b0000);
endmodule

// File: rtl/tx_sig_inserter.sv
module tx_sig_inserter
  import tsi_pkg::*;
#(
  parameter int NSLOT = 32,
  parameter int T1_CH = 24,
  localparam int SW   = $clog2(NSLOT),
  localparam int NREG = NSLOT / 2,
  localparam int RW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             in_vld,
  input  logic [SW-1:0]    slot_idx,
  input  logic [4:0]       frame_idx,
  input  logic [7:0]       pcm_in,
  input  logic [7:0]       sig_in,
  input  logic [NSLOT-1:0] sw_mask,
  input  logic [NSLOT-1:0] hw_mask,
  input  logic             wr_en,
  input  logic [RW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             stat_rd,
  output logic             out_vld,
  output logic [7:0]       pcm_out,
  output logic             stat_mf
);
  logic              mf_bnd;
  logic [NREG*8-1:0] shadow_flat;

  assign mf_bnd = in_vld && (slot_idx == '0) && (frame_idx == 5'd0);

  tsi_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mf_bnd(mf_bnd), .stat_rd(stat_rd), .shadow_flat(shadow_flat), .stat_mf(stat_mf)
  );

  tsi_insert #(.NSLOT(NSLOT), .T1_CH(T1_CH)) u_ins (
    .clk(clk), .rst(rst), .mode(sig_mode_e'(mode)), .in_vld(in_vld),
    .slot(slot_idx), .frame(frame_idx), .in_data(pcm_in), .sig_in(sig_in),
    .hw_mask(hw_mask), .sw_mask(sw_mask), .shadow_flat(shadow_flat),
    .out_vld(out_vld), .out_data(pcm_out)
  );
endmodule

// File: tb/tb_tx_sig_inserter.sv
`timescale 1ns/1ps
module tb_tx_sig_inserter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic        in_vld = 1'b0;
  logic [4:0]  slot_idx = '0, frame_idx = '0;
  logic [7:0]  pcm_in = '0, sig_in = '0;
  logic [31:0] sw_mask = '0, hw_mask = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        stat_rd = 1'b0;
  logic        out_vld, stat_mf;
  logic [7:0]  pcm_out;

  int total = 0, fails = 0;
  bit done = 0;
  logic [7:0] bank_m [16];
  logic [7:0] sh_m   [16];
  bit flag_m = 0;

  always #2 clk = ~clk;

  tx_sig_inserter dut (
    .clk(clk), .rst(rst), .mode(mode), .in_vld(in_vld), .slot_idx(slot_idx),
    .frame_idx(frame_idx), .pcm_in(pcm_in), .sig_in(sig_in), .sw_mask(sw_mask),
    .hw_mask(hw_mask), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat_rd(stat_rd), .out_vld(out_vld), .pcm_out(pcm_out), .stat_mf(stat_mf)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected byte from the requirements (R5..R12)
  function automatic logic [7:0] model(int md, int s, int f, logic [7:0] d, logic [7:0] g);
    logic [7:0] o = d;
    if (md <= 1 && s < 24) begin
      int k = -1;
      if (md == 0 && f % 6 == 5) k = f / 6;
      if (md == 1 && (f == 5 || f == 11)) k = f / 6;
      if (k >= 0 && (hw_mask[s] || sw_mask[s])) begin
        int nib = hw_mask[s] ? (g & 15) : ((sh_m[s/2] >> ((s % 2) ? 0 : 4)) & 15);
        o[0] = 1'((nib >> (3 - k)) & 1);
      end
    end else if (md == 2 && s == 16) begin
      if (f == 0) o = d & 8'h0F;
      else if (f < 16) begin
        if (hw_mask[f])           o[7:4] = g[7:4];
        else if (sw_mask[f])      o[7:4] = sh_m[f][7:4];
        if (hw_mask[f+16])        o[3:0] = g[3:0];
        else if (sw_mask[f+16])   o[3:0] = sh_m[f][3:0];
      end
    end
    return o;
  endfunction

  // One clock: drive at negedge, check at the next negedge.
  task automatic step(bit v, int s, int f, logic [7:0] d, logic [7:0] g,
                      bit we, int wa, logic [7:0] wd, bit rd, string req);
    logic [7:0] e;
    bit bnd;
    in_vld = v; slot_idx = 5'(s); frame_idx = 5'(f); pcm_in = d; sig_in = g;
    wr_en = we; wr_addr = 4'(wa); wr_data = wd; stat_rd = rd;
    e = model(mode, s, f, d, g);
    bnd = v && s == 0 && f == 0;
    @(posedge clk);
    @(negedge clk);
    if (bnd) for (int i = 0; i < 16; i++) sh_m[i] = bank_m[i];
    if (we) bank_m[wa] = wd;
    if (bnd) flag_m = 1; else if (rd) flag_m = 0;
    chk("R2 out_vld", out_vld, v);
    if (v) chk(req, pcm_out, e);
    chk("R4 stat_mf", stat_mf, flag_m);
  endtask

  task automatic run_mode(int md, int nfr, int slots, int nmf, string req);
    mode = 2'(md);
    for (int mf = 0; mf < nmf; mf++)
      for (int f = 0; f < nfr; f++)
        for (int s = 0; s < slots; s++) begin
          logic [7:0] d = 8'((s * 29 + f * 13 + mf * 7 + md) & 255);
          logic [7:0] g = 8'(((s * 5 + f * 3 + mf) & 255) ^ 8'hA5);
          bit we = 0; int wa = 0; logic [7:0] wd = 0;
          // R3: mid-multiframe write, then a write on the boundary beat
          if (mf == 1 && f == 3 && s == 2) begin we = 1; wa = 2;  wd = 8'h5A ^ 8'(md); end
          if (mf == 2 && f == 0 && s == 0) begin we = 1; wa = 5;  wd = 8'hC3 ^ 8'(md); end
          if (mf == 2 && f == 0 && s == 1) begin we = 1; wa = 1;  wd = 8'h96; end
          step(1, s, f, d, g, we, wa, wd, (f == 2 && s == 0), req);
        end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin bank_m[i] = 0; sh_m[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_vld", out_vld, 0);
    chk("R1 pcm_out", pcm_out, 0);
    chk("R1 stat_mf", stat_mf, 0);

    // Overlapping masks: both, bank only, serial only, neither (R10, R11)
    sw_mask = 32'h0F0F_33CC;
    hw_mask = 32'h00FF_0A50;

    // Nothing loaded yet: first boundary with the bank at reset content (R1, R3)
    run_mode(0, 1, 24, 1, "R1 empty bank");
    for (int r = 0; r < 16; r++)
      step(0, 0, 0, 0, 0, 1, r, 8'((r * 53 + 17) & 255), 0, "R5");
    run_mode(0, 24, 24, 3, "R6 ESF");
    run_mode(1, 12, 24, 3, "R7 D4");
    run_mode(2, 16, 32, 3, "R8 E1");
    // Serial only on all channels, then bank only (R9, R5)
    hw_mask = 32'hFFFF_FFFF;
    run_mode(0, 24, 24, 1, "R9 serial ESF");
    run_mode(2, 16, 32, 1, "R9 serial E1");
    hw_mask = 32'h0; sw_mask = 32'hFFFF_FFFF;
    run_mode(0, 24, 24, 1, "R5 bank ESF");
    sw_mask = 32'h0;
    run_mode(0, 24, 24, 1, "R11 no source");
    sw_mask = 32'hFFFF_FFFF; hw_mask = 32'hFFFF_0000;
    run_mode(3, 24, 32, 1, "R12 mode off");
    // Set and clear of the flag on the same beat (R4)
    mode = 2'b00;
    step(1, 0, 0, 8'h11, 8'h00, 0, 0, 0, 1, "R4 set wins");
    step(1, 1, 0, 8'h22, 8'h00, 0, 0, 0, 1, "R4 clear");
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule